// File: doc/BRIEF.md
# Processor Bus Address Decoder with Boot Vector Overlay

This block sits beside a 24-bit processor bus and classifies every access in the same cycle. An access is an address, a size code and a read/write flag, qualified by a valid strobe. The block raises exactly one select: main RAM, boot ROM, or one of ten peripheral windows. Beside the select it gives an offset into the chosen target. For peripheral windows that start on an odd address, registers sit on every other byte, so the offset is halved. An access that fits no target, or that is illegal, produces no select, and a bus-error pulse follows one cycle later.

Two pieces of state shape the map. After reset a boot overlay is active. During the overlay only the two initial longword vector fetches are legal, and both are steered into ROM. The fetch at address 4 ends the overlay. RAM above the low 64 KiB begins disabled. A single byte write to the first upper address stores that byte and switches the whole upper region on until the next reset. The block also merges the peripherals' request lines into one interrupt priority level.

The valid strobe is a plain qualifier with no ready. The decoder accepts one access on every cycle and never stalls the bus, so there is no back-pressure.

Top module: `bus_map_decoder`

## Requirements
- R1: After reset the boot overlay is active. A longword read (size 2) at address 0 or 4 selects ROM with offset equal to the address. The read at 4 ends the overlay from the next cycle onward.
- R2: While the overlay is active, any other valid access (other address, other size, or a write) raises no select and is flagged as a bus error.
- R3: Once the overlay has ended, address 0 decodes as ordinary low RAM (RAM offset equals the address).
- R4: Upper RAM (0x010000 up to 0x0FFFFF) starts disabled, and accesses there are errors. Word writes and byte reads at 0x010000 do not enable it. A byte write to exactly 0x010000 selects RAM and enables upper RAM for all later accesses. The RAM offset is always the full address.
- R5: Size codes are 0 for byte (1 byte), 1 for word (2 bytes) and 2 for long (4 bytes). A region matches only when address plus byte count is at most its end. Low RAM ends at 0x010000, upper RAM at 0x100000 and ROM at 0x110000.
- R6: ROM (0x100000 to 0x10FFFF) is selected for reads with offset = address − 0x100000. A write there gives no select and a bus error.
- R7: The peripheral windows are half-open. Index 0 is 0x180000–0x200000 and index 1 is 0x200000–0x280002. Indices 2 to 9 are consecutive 0x4000-byte windows starting at 0x3A0001. The bit sel_dev[i] is the window's select, and the lowest matching index wins. For an even window start the offset is address − start.
- R8: For an odd window start the offset is (address − start) / 2.
- R9: Interrupt levels per window index are: index 1 → 1, index 2 → 4, index 4 → 5, all others → 0. The output ipl is the largest level among asserted irq_req bits, or 0 when none is asserted.
- R10: bus_err is a registered pulse. It is high in the cycle after an erroring valid access and low after a legal or idle cycle. With acc_valid low, no select is raised and the offset is 0.
- R11: An address outside every region (for example 0x300000) and size code 3 are both bus errors with no select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 24 | Byte address of the access |
| acc_size | input | 2 | 0 byte, 1 word, 2 long, 3 illegal |
| acc_write | input | 1 | 1 for write, 0 for read |
| irq_req | input | 10 | Request line per peripheral window |
| sel_ram | output | 1 | RAM selected |
| sel_rom | output | 1 | ROM selected |
| sel_dev | output | 10 | One-hot peripheral window select |
| map_offset | output | 24 | Offset into the selected target |
| bus_err | output | 1 | Error pulse, one cycle after the access |
| ipl | output | 3 | Interrupt priority level |

## Verification
Accesses are placed just inside and just outside each region end with byte, word and long sizes. This tells the fit rule apart from a start-address-only check. Window 2 is hit at its last byte, which separates a halved offset from a plain one and the first-match order from a fall-through to window 3. The reset sequence mixes the legal vector fetches with an illegal word read and a write, so an overlay that ends too early, or that lets other accesses through, is caught. Upper-RAM probes come before and after the enabling write, and include a word write and a byte read that must not enable it. Request patterns mix level-0 devices with leveled ones, so that a priority encoder is distinguished from a lowest-index or OR-of-levels encoder.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
  localparam int ADDR_W = 24;
  localparam int DEV_N  = 10;
  localparam int LVL_W  = 3;
  localparam int DEV_STRIDE = 'h4000;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;
  localparam logic [1:0] SZ_BAD  = 2'd3;

  // window start, one bit wider than the bus to hold end addresses
  function automatic logic [ADDR_W:0] win_lo(input int idx);
    case (idx)
      0:       win_lo = 25'h180000;
      1:       win_lo = 25'h200000;
      default: win_lo = 25'h3A0001 + 25'(idx - 2) * 25'(DEV_STRIDE);
    endcase
  endfunction

  function automatic logic [ADDR_W:0] win_hi(input int idx);
    case (idx)
      0:       win_hi = 25'h200000;
      1:       win_hi = 25'h280002;
      default: win_hi = win_lo(idx) + 25'(DEV_STRIDE);
    endcase
  endfunction

  function automatic logic [LVL_W-1:0] win_lvl(input int idx);
    case (idx)
      1:       win_lvl = 3'd1;
      2:       win_lvl = 3'd4;
      4:       win_lvl = 3'd5;
      default: win_lvl = 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_WORD: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/bmd_window.sv
module bmd_window
  import bmd_pkg::*;
#(
  parameter logic [ADDR_W:0] LO = '0,
  parameter logic [ADDR_W:0] HI = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        nbytes,
  output logic              hit,
  output logic [ADDR_W-1:0] offset
);
  logic [ADDR_W:0]   a_ext;
  logic [ADDR_W:0]   a_end;
  logic [ADDR_W-1:0] diff;

  always_comb begin
    a_ext = {1'b0, addr};
    a_end = a_ext + {{(ADDR_W-2){1'b0}}, nbytes};
    hit   = (a_ext >= LO) && (a_end <= HI);
    diff  = addr - LO[ADDR_W-1:0];
  end

  generate
    if (LO[0]) begin : g_odd
      assign offset = {1'b0, diff[ADDR_W-1:1]};
    end else begin : g_even
      assign offset = diff;
    end
  endgenerate
endmodule

// File: rtl/bmd_irq_level.sv
module bmd_irq_level
  import bmd_pkg::*;
(
  input  logic [DEV_N-1:0] irq_req,
  output logic [LVL_W-1:0] ipl
);
  always_comb begin
    ipl = '0;
    for (int i = 0; i < DEV_N; i++) begin
      if (irq_req[i] && (win_lvl(i) > ipl)) ipl = win_lvl(i);
    end
  end
endmodule

// File: rtl/bmd_boot_ctrl.sv
module bmd_boot_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic vec_done,
  input  logic hiram_arm,
  output logic boot_q,
  output logic hiram_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      boot_q  <= 1'b1;
      hiram_q <= 1'b0;
    end else begin
      if (vec_done)  boot_q  <= 1'b0;
      if (hiram_arm) hiram_q <= 1'b1;
    end
  end

  // R1: the second vector fetch closes the overlay
  a_r1_vec_ends_overlay: assert property (@(posedge clk) disable iff (rst)
    vec_done |=> !boot_q);
  // R1: once closed, the overlay stays closed until reset
  a_r1_overlay_no_return: assert property (@(posedge clk) disable iff (rst)
    !boot_q |=> !boot_q);
  // R4: upper RAM enable is sticky
  a_r4_hiram_sticky: assert property (@(posedge clk) disable iff (rst)
    hiram_q |=> hiram_q);
endmodule

// File: rtl/bus_map_decoder.sv
module bus_map_decoder
  import bmd_pkg::*;
#(
  parameter int unsigned LOW_TOP  = 'h010000,
  parameter int unsigned RAM_TOP  = 'h100000,
  parameter int unsigned ROM_BASE = 'h100000,
  parameter int unsigned ROM_TOP  = 'h110000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic              acc_write,
  input  logic [DEV_N-1:0]  irq_req,
  output logic              sel_ram,
  output logic              sel_rom,
  output logic [DEV_N-1:0]  sel_dev,
  output logic [ADDR_W-1:0] map_offset,
  output logic              bus_err,
  output logic [LVL_W-1:0]  ipl
);
  localparam logic [ADDR_W:0]   LOW_TOP_X  = (ADDR_W+1)'(LOW_TOP);
  localparam logic [ADDR_W:0]   RAM_TOP_X  = (ADDR_W+1)'(RAM_TOP);
  localparam logic [ADDR_W:0]   ROM_BASE_X = (ADDR_W+1)'(ROM_BASE);
  localparam logic [ADDR_W:0]   ROM_TOP_X  = (ADDR_W+1)'(ROM_TOP);
  localparam logic [ADDR_W-1:0] HIRAM_KEY  = LOW_TOP_X[ADDR_W-1:0];

  logic              boot_q, hiram_q;
  logic              vec_done, hiram_arm, dec_err, vec_legal;
  logic [ADDR_W-1:0] eff_addr;
  logic [2:0]        nbytes;

  logic              low_hit, hi_hit, rom_hit;
  logic [ADDR_W-1:0] low_off, hi_off, rom_off;
  logic [DEV_N-1:0]  dev_hit, dev_pick;
  logic [ADDR_W-1:0] dev_off [DEV_N];
  logic [ADDR_W-1:0] dev_off_sel;

  // overlay steers vector fetches into ROM
  assign eff_addr = boot_q ? (acc_addr + ROM_BASE_X[ADDR_W-1:0]) : acc_addr;
  assign nbytes   = size_bytes(acc_size);

  bmd_window #(.LO('0), .HI(LOW_TOP_X)) u_low (
    .addr(eff_addr), .nbytes(nbytes), .hit(low_hit), .offset(low_off));
  bmd_window #(.LO(LOW_TOP_X), .HI(RAM_TOP_X)) u_hiram (
    .addr(eff_addr), .nbytes(nbytes), .hit(hi_hit), .offset(hi_off));
  bmd_window #(.LO(ROM_BASE_X), .HI(ROM_TOP_X)) u_rom (
    .addr(eff_addr), .nbytes(nbytes), .hit(rom_hit), .offset(rom_off));

  generate
    for (genvar i = 0; i < DEV_N; i++) begin : g_dev
      bmd_window #(.LO(win_lo(i)), .HI(win_hi(i))) u_win (
        .addr(eff_addr), .nbytes(nbytes), .hit(dev_hit[i]), .offset(dev_off[i]));
    end
  endgenerate

  // lowest matching window wins
  assign dev_pick = dev_hit & (~dev_hit + 1'b1);

  always_comb begin
    dev_off_sel = '0;
    for (int i = 0; i < DEV_N; i++) begin
      if (dev_pick[i]) dev_off_sel = dev_off[i];
    end
  end

  assign vec_legal = !acc_write && (acc_size == SZ_LONG) && rom_hit &&
                     ((acc_addr == 24'd0) || (acc_addr == 24'd4));

  always_comb begin
    sel_ram    = 1'b0;
    sel_rom    = 1'b0;
    sel_dev    = '0;
    map_offset = '0;
    dec_err    = 1'b0;
    vec_done   = 1'b0;
    hiram_arm  = 1'b0;
    if (acc_valid) begin
      if (acc_size == SZ_BAD) begin
        dec_err = 1'b1;
      end else if (boot_q) begin
        if (vec_legal) begin
          sel_rom    = 1'b1;
          map_offset = rom_off;
          vec_done   = (acc_addr == 24'd4);
        end else begin
          dec_err = 1'b1;
        end
      end else if (hiram_q && hi_hit) begin
        sel_ram    = 1'b1;
        map_offset = hi_off + HIRAM_KEY;
      end else if (!acc_write && rom_hit) begin
        sel_rom    = 1'b1;
        map_offset = rom_off;
      end else if (|dev_hit) begin
        sel_dev    = dev_pick;
        map_offset = dev_off_sel;
      end else if (low_hit) begin
        sel_ram    = 1'b1;
        map_offset = low_off;
      end else if (acc_write && (acc_size == SZ_BYTE) && (acc_addr == HIRAM_KEY)) begin
        sel_ram    = 1'b1;
        map_offset = acc_addr;
        hiram_arm  = 1'b1;
      end else begin
        dec_err = 1'b1;
      end
    end
  end

  bmd_boot_ctrl u_boot (
    .clk(clk), .rst(rst), .vec_done(vec_done), .hiram_arm(hiram_arm),
    .boot_q(boot_q), .hiram_q(hiram_q));

  bmd_irq_level u_irq (.irq_req(irq_req), .ipl(ipl));

  always_ff @(posedge clk) begin
    if (rst) bus_err <= 1'b0;
    else     bus_err <= dec_err;
  end

  // R7: never more than one target selected
  a_r7_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_ram, sel_rom, sel_dev}));
  // R6: a write never selects ROM
  a_r6_rom_no_write: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write) |-> !sel_rom);
  // R10: an unclaimed valid access is followed by an error pulse
  a_r10_err_follows: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !(sel_ram || sel_rom || (|sel_dev))) |=> bus_err);
  // R10: an idle cycle is never followed by an error pulse
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !bus_err);
  // R9: no request, no level
  a_r9_idle_level: assert property (@(posedge clk) disable iff (rst)
    (irq_req == '0) |-> (ipl == '0));
  // R9: the level-1 device always lifts the level to at least 1
  a_r9_dev1_floor: assert property (@(posedge clk) disable iff (rst)
    irq_req[1] |-> (ipl >= 3'd1));
endmodule

// File: tb/bus_map_decoder_test.sv
module bus_map_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [23:0] acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic        acc_write = 1'b0;
  logic [9:0]  irq_req = '0;
  logic        sel_ram, sel_rom, bus_err;
  logic [9:0]  sel_dev;
  logic [23:0] map_offset;
  logic [2:0]  ipl;

  int n_vec = 0;
  int n_bad = 0;

  typedef struct {
    logic        ram;
    logic        rom;
    logic [9:0]  dev;
    logic [23:0] off;
    logic        err;
    logic [2:0]  ipl;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  always #2 clk = ~clk;

  bus_map_decoder uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_write(acc_write), .irq_req(irq_req),
    .sel_ram(sel_ram), .sel_rom(sel_rom), .sel_dev(sel_dev),
    .map_offset(map_offset), .bus_err(bus_err), .ipl(ipl));

  // driver: one access per cycle, expected result pushed to the scoreboard
  task automatic step(input logic v, input logic [23:0] a, input logic [1:0] sz,
                      input logic wr, input logic [9:0] req,
                      input logic eram, input logic erom, input logic [9:0] edev,
                      input logic [23:0] eoff, input logic eerr,
                      input logic [2:0] eipl, input string tag);
    exp_t e;
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_size = sz; acc_write = wr; irq_req = req;
    e.ram = eram; e.rom = erom; e.dev = edev; e.off = eoff;
    e.err = eerr; e.ipl = eipl; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: combinational results in the access cycle, error pulse one later
  initial begin
    logic prev_err;
    exp_t e;
    prev_err = 1'b0;
    forever begin
      @(negedge clk);
      #1;
      n_vec++;
      if (bus_err !== prev_err) begin
        n_bad++;
        $display("FAIL R10 bus_err actual=%0b expected=%0b", bus_err, prev_err);
      end
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        n_vec++;
        if (sel_ram !== e.ram || sel_rom !== e.rom || sel_dev !== e.dev ||
            map_offset !== e.off || ipl !== e.ipl) begin
          n_bad++;
          $display("FAIL %s actual ram=%0b rom=%0b dev=%h off=%h ipl=%0d expected ram=%0b rom=%0b dev=%h off=%h ipl=%0d",
                   e.tag, sel_ram, sel_rom, sel_dev, map_offset, ipl,
                   e.ram, e.rom, e.dev, e.off, e.ipl);
        end
        prev_err = e.err;
      end else begin
        prev_err = 1'b0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    //   v  addr        sz  wr req     ram  rom  dev     off        err  ipl
    step(0, 24'h000000, 0, 0, 10'h0,  0,   0,   10'h0,  24'h0,     0,   0, "R10 reset idle");
    step(1, 24'h000000, 1, 0, 10'h0,  0,   0,   10'h0,  24'h0,     1,   0, "R2 word read in overlay");
    step(1, 24'h000000, 2, 0, 10'h0,  0,   1,   10'h0,  24'h0,     0,   0, "R1 vector 0");
    step(1, 24'h000004, 2, 1, 10'h0,  0,   0,   10'h0,  24'h0,     1,   0, "R2 write in overlay");
    step(1, 24'h000004, 2, 0, 10'h0,  0,   1,   10'h0,  24'h4,     0,   0, "R1 vector 4");
    step(1, 24'h000000, 2, 0, 10'h0,  1,   0,   10'h0,  24'h0,     0,   0, "R3 low RAM after overlay");
    step(1, 24'h00FFFC, 2, 0, 10'h0,  1,   0,   10'h0,  24'h00FFFC,0,   0, "R5 low RAM last long");
    step(1, 24'h00FFFE, 2, 0, 10'h0,  0,   0,   10'h0,  24'h0,     1,   0, "R5 low RAM overrun");
    step(1, 24'h020000, 0, 0, 10'h0,  0,   0,   10'h0,  24'h0,     1,   0, "R4 upper RAM disabled");
    step(1, 24'h010000, 1, 1, 10'h0,  0,   0,   10'h0,  24'h0,     1,   0, "R4 word write no enable");
    step(1, 24'h010000, 0, 0, 10'h0,  0,   0,   10'h0,  24'h0,     1,   0, "R4 byte read no enable");
    step(1, 24'h010000, 0, 1, 10'h0,  1,   0,   10'h0,  24'h010000,0,   0, "R4 enabling byte write");
    step(1, 24'h020000, 2, 0, 10'h0,  1,   0,   10'h0,  24'h020000,0,   0, "R4 upper RAM enabled");
    step(1, 24'h0FFFFC, 2, 0, 10'h0,  1,   0,   10'h0,  24'h0FFFFC,0,   0, "R5 upper RAM last long");
    step(1, 24'h0FFFFE, 2, 0, 10'h0,  0,   0,   10'h0,  24'h0,     1,   0, "R5 upper RAM overrun");
    step(1, 24'h100000, 1, 0, 10'h0,  0,   1,   10'h0,  24'h0,     0,   0, "R6 ROM read");
    step(1, 24'h100002, 0, 1, 10'h0,  0,   0,   10'h0,  24'h0,     1,   0, "R6 ROM write");
    step(1, 24'h10FFFC, 2, 0, 10'h0,  0,   1,   10'h0,  24'h00FFFC,0,   0, "R5 ROM last long");
    step(1, 24'h10FFFE, 2, 0, 10'h0,  0,   0,   10'h0,  24'h0,     1,   0, "R5 ROM overrun");
    step(1, 24'h180010, 1, 0, 10'h0,  0,   0,   10'h001,24'h000010,0,   0, "R7 window 0");
    step(1, 24'h27FFFE, 2, 0, 10'h0,  0,   0,   10'h002,24'h07FFFE,0,   0, "R7 window 1 end");
    step(1, 24'h3A8005, 0, 0, 10'h0,  0,   0,   10'h010,24'h000002,0,   0, "R8 window 4 halved");
    step(1, 24'h3BC001, 0, 1, 10'h0,  0,   0,   10'h200,24'h000000,0,   0, "R8 window 9 base");
    step(1, 24'h3A4000, 0, 0, 10'h0,  0,   0,   10'h004,24'h001FFF,0,   0, "R8 window 2 last byte");
    step(1, 24'h3A4000, 1, 0, 10'h0,  0,   0,   10'h0,  24'h0,     1,   0, "R5 word across windows");
    step(1, 24'h300000, 0, 0, 10'h0,  0,   0,   10'h0,  24'h0,     1,   0, "R11 unmapped");
    step(1, 24'h000000, 3, 0, 10'h0,  0,   0,   10'h0,  24'h0,     1,   0, "R11 illegal size");
    step(0, 24'h000000, 0, 0, 10'h008,0,   0,   10'h0,  24'h0,     0,   0, "R9 level-0 device");
    step(0, 24'h000000, 0, 0, 10'h002,0,   0,   10'h0,  24'h0,     0,   1, "R9 device 1");
    step(0, 24'h000000, 0, 0, 10'h006,0,   0,   10'h0,  24'h0,     0,   4, "R9 devices 1 and 2");
    step(0, 24'h000000, 0, 0, 10'h014,0,   0,   10'h0,  24'h0,     0,   5, "R9 devices 2 and 4");
    step(0, 24'h000000, 0, 0, 10'h3FF,0,   0,   10'h0,  24'h0,     0,   5, "R9 all requests");
    step(0, 24'h180000, 0, 0, 10'h0,  0,   0,   10'h0,  24'h0,     0,   0, "R10 invalid ignored");
    repeat (3) @(negedge clk);
    #2;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule